// File: doc/BRIEF.md
# Multicycle Conditional Arithmetic Datapath

This block evaluates a two-way arithmetic expression on four 8-bit signed operands using a fixed schedule over shared hardware. It has one add/subtract ALU, one multicycle multiplier and one multicycle divider. A controller steps these units through the work. The branch depends on the parity of the first sum. When a+d is odd, the result is p = (a+d)*2 + ((b+c)-1)/4. When a+d is even, the result is p = (b+c)*2 + d.

There are only two operand ports, so the operands arrive in two pairs. An output, `pair_sel`, tells the environment which pair to present:

- While `pair_sel` is low, the ports must carry a and d.
- While `pair_sel` is high, the ports must carry b and c.

Both operand ports and the result port are registered. When the result is ready, a one-cycle `done` pulse marks it. Only one computation runs at a time.

Top module: `cond_arith_dp`

## Requirements
- R1: When a+d (wrapped to 8 bits) is odd, p equals (a+d)*2 + ((b+c)-1)/4.
- R2: When a+d (wrapped to 8 bits) is even, p equals (b+c)*2 + d.
- R3: Every sum, difference and product wraps modulo 256, and the result is the low 8 bits read as two's complement.
- R4: The division by 4 is signed and truncates toward zero. For example, -5/4 = -1 and -1/4 = 0.
- R5: `pair_sel` is low while idle. It is high for exactly the one cycle after the rising edge that accepts `start`. During that cycle, the environment must drive b on `opnd_x` and c on `opnd_y`. At all other times it must drive a on `opnd_x` and d on `opnd_y`.
- R6: `done` is high for one cycle. `p` changes only on the edge that raises `done`, and it holds its value until the next completion.
- R7: A `start` raised while a computation is in progress is ignored. It produces no extra `done`, no `pair_sel` pulse and no change of `p`.
- R8: After reset, `p` is 0 and both `done` and `pair_sel` are low.
- R9: Counting from the edge that accepts `start`, `done` is seen after the 9th rising edge on the even branch and after the 10th on the odd branch. The multiply and divide each take 4 cycles, and the two run in lockstep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Starts a computation when idle |
| opnd_x | input | 8 | Operand port X: carries a, or b while `pair_sel` is high |
| opnd_y | input | 8 | Operand port Y: carries d, or c while `pair_sel` is high |
| pair_sel | output | 1 | Operand pair request: low selects a/d, high selects b/c |
| p | output | 8 | Registered signed result |
| done | output | 1 | One-cycle pulse when `p` is updated |

## Verification
The assertions watch the following on every cycle:

- `done` and `pair_sel` are single-cycle pulses.
- `p` is frozen whenever `done` is low.
- A busy `start` never produces a pair request.
- The multiply and divide units finish together and are never relaunched while running.

Only the bench scenarios can show that the values are right. They cover both parity branches, wrap-around, rounding toward zero on negative quotients, the exact latency of each branch, and the outputs after an ignored `start`.

// File: rtl/cad_pkg.sv
package cad_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PAIR1,
        ST_PAIR2,
        ST_DEC,
        ST_LAUNCH,
        ST_WAIT,
        ST_FIN
    } cad_state_e;

endpackage

// File: rtl/cad_alu.sv
module cad_alu #(
    parameter int W = 8
) (
    input  logic         sub,
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    output logic [W-1:0] r
);
    // Single shared adder; subtraction by inverted operand and carry-in.
    always_comb begin
        r = x + (sub ? ~y : y) + {{(W-1){1'b0}}, sub};
    end
endmodule

// File: rtl/cad_mul.sv
module cad_mul #(
    parameter int W   = 8,
    parameter int LAT = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         go,
    input  logic [W-1:0] opa,
    input  logic [W-1:0] opb,
    output logic         done,
    output logic [W-1:0] res
);
    localparam int STEP = W / LAT;
    localparam int CW   = (LAT > 1) ? $clog2(LAT) : 1;

    typedef struct packed {
        logic         run;
        logic [CW-1:0] cnt;
        logic [W-1:0] acc;
        logic [W-1:0] mc;
        logic [W-1:0] mp;
        logic         done;
    } mul_t;

    mul_t mul_d, mul_q;

    always_comb begin
        mul_d      = mul_q;
        mul_d.done = 1'b0;
        if (go) begin
            mul_d.run = 1'b1;
            mul_d.cnt = '0;
            mul_d.acc = '0;
            mul_d.mc  = opa;
            mul_d.mp  = opb;
        end else if (mul_q.run) begin
            for (int i = 0; i < STEP; i++) begin
                if (mul_d.mp[0]) mul_d.acc = mul_d.acc + mul_d.mc;
                mul_d.mc = mul_d.mc << 1;
                mul_d.mp = mul_d.mp >> 1;
            end
            if (mul_q.cnt == CW'(LAT - 1)) begin
                mul_d.run  = 1'b0;
                mul_d.done = 1'b1;
            end else begin
                mul_d.cnt = mul_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mul_q <= '0;
        else        mul_q <= mul_d;
    end

    assign done = mul_q.done;
    assign res  = mul_q.acc;

    AST_MUL_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        go |-> !mul_q.run); // R9

endmodule

// File: rtl/cad_div.sv
module cad_div #(
    parameter int W   = 8,
    parameter int LAT = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         go,
    input  logic [W-1:0] opa,
    input  logic [W-1:0] opb,
    output logic         done,
    output logic [W-1:0] res
);
    localparam int STEP = W / LAT;
    localparam int CW   = (LAT > 1) ? $clog2(LAT) : 1;

    typedef struct packed {
        logic          run;
        logic [CW-1:0] cnt;
        logic [W:0]    rem;
        logic [W-1:0]  quo;
        logic [W-1:0]  dvs;
        logic          neg;
        logic          done;
    } div_t;

    div_t div_d, div_q;

    always_comb begin
        div_d      = div_q;
        div_d.done = 1'b0;
        if (go) begin
            div_d.run = 1'b1;
            div_d.cnt = '0;
            div_d.rem = '0;
            div_d.neg = opa[W-1] ^ opb[W-1];
            div_d.quo = opa[W-1] ? (~opa + 1'b1) : opa;
            div_d.dvs = opb[W-1] ? (~opb + 1'b1) : opb;
        end else if (div_q.run) begin
            for (int i = 0; i < STEP; i++) begin
                div_d.rem = {div_d.rem[W-1:0], div_d.quo[W-1]};
                div_d.quo = {div_d.quo[W-2:0], 1'b0};
                if (div_d.rem >= {1'b0, div_d.dvs}) begin
                    div_d.rem    = div_d.rem - {1'b0, div_d.dvs};
                    div_d.quo[0] = 1'b1;
                end
            end
            if (div_q.cnt == CW'(LAT - 1)) begin
                div_d.run  = 1'b0;
                div_d.done = 1'b1;
            end else begin
                div_d.cnt = div_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_d;
    end

    assign done = div_q.done;
    assign res  = div_q.neg ? (~div_q.quo + 1'b1) : div_q.quo;

    AST_DIV_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        go |-> !div_q.run); // R9

endmodule

// File: rtl/cond_arith_dp.sv
module cond_arith_dp #(
    parameter int W   = 8,
    parameter int LAT = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] opnd_x,
    input  logic [W-1:0] opnd_y,
    output logic         pair_sel,
    output logic [W-1:0] p,
    output logic         done
);
    import cad_pkg::*;

    localparam logic [W-1:0] ONE  = W'(1);
    localparam logic [W-1:0] TWO  = W'(2);
    localparam logic [W-1:0] FOUR = W'(4);

    typedef struct packed {
        cad_state_e   st;
        logic [W-1:0] ix;
        logic [W-1:0] iy;
        logic [W-1:0] rs;
        logic [W-1:0] rt;
        logic [W-1:0] rd;
        logic         odd;
        logic [W-1:0] p;
        logic         done;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic         alu_sub;
    logic [W-1:0] alu_x, alu_y, alu_r;
    logic         unit_go;
    logic [W-1:0] mul_a, mul_res, div_res;
    logic         mul_done, div_done;

    cad_alu #(.W(W)) u_alu (
        .sub(alu_sub), .x(alu_x), .y(alu_y), .r(alu_r)
    );

    cad_mul #(.W(W), .LAT(LAT)) u_mul (
        .clk(clk), .rst_n(rst_n), .go(unit_go), .opa(mul_a), .opb(TWO),
        .done(mul_done), .res(mul_res)
    );

    cad_div #(.W(W), .LAT(LAT)) u_div (
        .clk(clk), .rst_n(rst_n), .go(unit_go), .opa(ctl_q.rt), .opb(FOUR),
        .done(div_done), .res(div_res)
    );

    assign mul_a = ctl_q.odd ? ctl_q.rs : ctl_q.rt;

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.ix   = opnd_x;
        ctl_d.iy   = opnd_y;
        ctl_d.done = 1'b0;
        alu_sub    = 1'b0;
        alu_x      = ctl_q.ix;
        alu_y      = ctl_q.iy;
        unit_go    = 1'b0;
        case (ctl_q.st)
            ST_IDLE: begin
                if (start) ctl_d.st = ST_PAIR1;
            end
            ST_PAIR1: begin
                ctl_d.rs  = alu_r;
                ctl_d.odd = alu_r[0];
                ctl_d.rd  = ctl_q.iy;
                ctl_d.st  = ST_PAIR2;
            end
            ST_PAIR2: begin
                ctl_d.rt = alu_r;
                ctl_d.st = ctl_q.odd ? ST_DEC : ST_LAUNCH;
            end
            ST_DEC: begin
                alu_sub  = 1'b1;
                alu_x    = ctl_q.rt;
                alu_y    = ONE;
                ctl_d.rt = alu_r;
                ctl_d.st = ST_LAUNCH;
            end
            ST_LAUNCH: begin
                unit_go  = 1'b1;
                ctl_d.st = ST_WAIT;
            end
            ST_WAIT: begin
                if (mul_done) ctl_d.st = ST_FIN;
            end
            ST_FIN: begin
                alu_x      = mul_res;
                alu_y      = ctl_q.odd ? div_res : ctl_q.rd;
                ctl_d.p    = alu_r;
                ctl_d.done = 1'b1;
                ctl_d.st   = ST_IDLE;
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q    <= '0;
            ctl_q.st <= ST_IDLE;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign pair_sel = (ctl_q.st == ST_PAIR1);
    assign p        = ctl_q.p;
    assign done     = ctl_q.done;

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R6
    AST_P_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(p)); // R6
    AST_PAIR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        pair_sel |=> !pair_sel); // R5
    AST_BUSY_START: assert property (@(posedge clk) disable iff (!rst_n)
        (start && ctl_q.st != ST_IDLE) |=> !pair_sel); // R7
    AST_UNITS_LOCKSTEP: assert property (@(posedge clk) disable iff (!rst_n)
        mul_done |-> div_done); // R9

endmodule

// File: tb/cond_arith_dp_bench.sv
module cond_arith_dp_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [7:0] va = 8'h0, vb = 8'h0, vc = 8'h0, vd = 8'h0;
    logic [7:0] opnd_x, opnd_y, p;
    logic       pair_sel, done;
    int         checks = 0;
    int         errors = 0;
    int         cycles = 0;

    always #5 clk = ~clk;

    assign opnd_x = pair_sel ? vb : va;
    assign opnd_y = pair_sel ? vc : vd;

    cond_arith_dp u_cond_arith_dp (
        .clk(clk), .rst_n(rst_n), .start(start), .opnd_x(opnd_x),
        .opnd_y(opnd_y), .pair_sel(pair_sel), .p(p), .done(done)
    );

    // {a, b, c, d, expected p}
    localparam logic [39:0] VEC [10] = '{
        {8'h03, 8'h0A, 8'h07, 8'h02, 8'h0E},  // R1 odd
        {8'h04, 8'h05, 8'h06, 8'h02, 8'h18},  // R2 even
        {8'h01, 8'hFD, 8'hFF, 8'h00, 8'h01},  // R4 -5/4 = -1
        {8'h64, 8'h64, 8'h64, 8'h01, 8'hBC},  // R3 wrap, odd
        {8'h00, 8'h78, 8'h0A, 8'hFE, 8'h02},  // R3 wrap, even
        {8'h80, 8'h00, 8'h00, 8'hFF, 8'hFE},  // R4 -1/4 = 0
        {8'hFB, 8'hF9, 8'h02, 8'h03, 8'hF9},  // R2 negatives
        {8'h07, 8'h80, 8'h01, 8'h00, 8'hEE},  // R4 -128/4
        {8'h00, 8'h00, 8'h01, 8'h01, 8'h02},  // R1 zero quotient
        {8'h00, 8'h00, 8'h00, 8'h00, 8'h00}   // R2 all zero
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] ref_p(input logic [7:0] a, b, c, d);
        logic [7:0] s, t, qv;
        int q;
        s = a + d;
        t = b + c;
        if (s[0]) begin
            t  = t - 8'd1;
            q  = $signed(t) / 4;
            qv = 8'(q);
            return 8'(s * 8'd2 + qv);
        end
        return 8'(t * 8'd2 + d);
    endfunction

    task automatic run_op(input logic [7:0] a, b, c, d, output logic [7:0] res, output int lat);
        @(negedge clk);
        va = a; vb = b; vc = c; vd = d;
        start = 1'b1;
        @(posedge clk);
        #1;
        start = 1'b0;
        check(pair_sel == 1'b1, "R5 pair_sel high after accept", pair_sel, 1);
        lat = 0;
        while (lat < 40) begin
            @(posedge clk);
            #1;
            lat++;
            if (lat == 1) check(pair_sel == 1'b0, "R5 pair_sel one cycle", pair_sel, 0);
            if (done) break;
        end
        res = p;
        @(posedge clk);
        #1;
        check(done == 1'b0, "R6 done one cycle", done, 0);
        check(p == res, "R6 p held", p, res);
    endtask

    initial begin
        while (1) begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                errors++;
                $display("FAIL watchdog: actual %0d expected below 100000", cycles);
                $display("Simulation finished: %0d checks, %0d errors", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        logic [7:0] res, held, s;
        int lat;
        repeat (3) @(posedge clk);
        #1;
        check(p == 8'h00, "R8 reset p", p, 0);
        check(done == 1'b0, "R8 reset done", done, 0);
        check(pair_sel == 1'b0, "R8 reset pair_sel", pair_sel, 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        check(p == 8'h00 && !done && !pair_sel, "R8 after release", p, 0);

        // table walk: R1 R2 R3 R4 R9
        for (int i = 0; i < 10; i++) begin
            logic [7:0] ea, eb, ec, ed, ep;
            {ea, eb, ec, ed, ep} = VEC[i];
            run_op(ea, eb, ec, ed, res, lat);
            s = ea + ed;
            check(res == ep, s[0] ? "R1 R3 R4 odd branch value" : "R2 R3 even branch value", res, ep);
            check(lat == (s[0] ? 10 : 9), "R9 latency", lat, s[0] ? 10 : 9);
        end

        // random operands vs reference, both branches
        for (int i = 0; i < 200; i++) begin
            logic [7:0] ra, rb, rc, rd, ep;
            ra = 8'($urandom); rb = 8'($urandom); rc = 8'($urandom); rd = 8'($urandom);
            ep = ref_p(ra, rb, rc, rd);
            run_op(ra, rb, rc, rd, res, lat);
            s = ra + rd;
            check(res == ep, s[0] ? "R1 random odd" : "R2 random even", res, ep);
            check(lat == (s[0] ? 10 : 9), "R9 random latency", lat, s[0] ? 10 : 9);
        end

        // R7: start while busy is ignored
        @(negedge clk);
        va = 8'h03; vb = 8'h0A; vc = 8'h07; vd = 8'h02;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (2) @(negedge clk);
        va = 8'h04; vb = 8'h05; vc = 8'h06; vd = 8'h02;
        start = 1'b1;
        repeat (2) @(negedge clk);
        start = 1'b0;
        lat = 0;
        while (!done && lat < 40) begin
            @(posedge clk);
            #1;
            lat++;
        end
        check(p == 8'h0E, "R7 busy start kept first result", p, 8'h0E);
        held = p;
        begin
            int extra = 0;
            int sel = 0;
            for (int k = 0; k < 15; k++) begin
                @(posedge clk);
                #1;
                if (done) extra++;
                if (pair_sel) sel++;
            end
            check(extra == 0, "R7 no extra done", extra, 0);
            check(sel == 0, "R7 no extra pair request", sel, 0);
            check(p == held, "R7 p unchanged", p, held);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule